// File: doc/BRIEF.md
# Hardware Thread Context Scheduler

This block picks the hardware thread that supplies the next fetched instruction in a small in-order pipeline. It holds one program counter per thread and presents the active thread's PC, its thread number and a valid flag to instruction fetch. It also keeps a one-entry tag record for the instruction that was fetched in the previous cycle and now sits in the slot ahead of execute. Later stages receive that tag with the instruction so that each result can be matched to its thread.

The scheduling policy is chosen when the block is built. In block mode the active thread keeps fetching until the execute stage reports an event for it, such as a cache miss, a yield or the start of a long-latency operation. The scheduler then hands fetch to the next ready thread in round-robin order. It kills the instruction of the old thread that sits in the slot and rewinds that thread's PC so the instruction is fetched again when the thread resumes. In interleaved mode the thread number steps by one every cycle without any condition, so the threads issue in strict rotation. Branch redirects tagged with a thread number change only the PC of that thread.

Top module: `ctx_sched`

## Requirements
- R1: While reset is asserted and just after it is released, the active thread is 0, every thread's PC equals the boot address (default 0x100) and the slot tag is invalid.
- R2: `fetch_pc` is the PC of thread `fetch_tid`. A thread's PC moves forward by the step size (default 4) only in a cycle in which that thread fetches with `fetch_valid` high.
- R3: In block mode the active thread changes only when an event is tagged with the active thread and at least one other thread is ready. The new thread is the first ready thread found after the current one, searching upward and wrapping modulo the thread count. Threads whose ready bit is 0 are skipped.
- R4: In block mode an event whose thread tag differs from the active thread has no effect: no switch, no flush, and the fetch goes ahead.
- R5: In block mode an event from the active thread when no other thread is ready causes no switch and no flush, and fetch continues as it would for a single-threaded core.
- R6: In the cycle of a block-mode switch, `fetch_valid` is 0. `fetch_flush` is 1 exactly when the slot holds a valid instruction, and the slot is invalid in the next cycle.
- R7: When the flushed slot instruction belongs to the old thread, that thread's PC is restored to the PC of the flushed instruction. The thread refetches it when it next becomes active.
- R8: A redirect (`redir_valid` high) loads `redir_pc` into the PC of `redir_tid` only. It takes priority over the advance in the same cycle and leaves all other PCs unchanged.
- R9: In interleaved mode `fetch_tid` increases by one modulo the thread count every cycle, whatever the ready bits and events. `fetch_flush` is never raised. `fetch_valid` equals the ready bit of `fetch_tid`.
- R10: Unless a flush occurs, `slot_valid` and `slot_tid` in a cycle equal `fetch_valid` and `fetch_tid` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | NUM_THREADS | Per-thread ready flags |
| ex_event | input | 1 | Switch event from the execute stage (miss, yield, long operation) |
| ex_event_tid | input | TID_W | Thread tag of the instruction raising the event |
| redir_valid | input | 1 | Branch redirect request |
| redir_tid | input | TID_W | Thread whose PC is redirected |
| redir_pc | input | PC_W | Redirect target |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| fetch_tid | output | TID_W | Thread supplying this fetch |
| fetch_pc | output | PC_W | Address to fetch |
| fetch_flush | output | 1 | Kill the instruction held in the fetch slot |
| slot_valid | output | 1 | The slot holds a live instruction |
| slot_tid | output | TID_W | Thread tag travelling with the slot instruction |

## Verification
The bench targets these corner cases of the block:
- An event tagged with a thread other than the active one. A design that checks only the event pulse would switch threads on stale in-flight events.
- A switch when only the active thread is ready. Here a wrong design flushes with nowhere to go and loses throughput on a single-threaded load.
- A round-robin search that must skip unready threads and wrap from the top thread back to 0. An off-by-one picker shows up as the wrong `fetch_tid`.
- A switch with an empty slot, and the later refetch of a flushed instruction. A design that forgets the rewind resumes the old thread one step late, skipping an instruction.
- Redirects that coincide with an advance of the same thread.
- In interleaved mode, rotation through an unready thread. That thread's PC must hold still while the others move on.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

    // Build-time scheduling policy
    typedef enum logic {
        SCHED_BLOCK      = 1'b0,  // switch on execute-stage events only
        SCHED_INTERLEAVE = 1'b1   // rotate threads every cycle
    } sched_mode_e;

endpackage

// File: rtl/ctx_rr_pick.sv
// Round-robin search: first ready thread strictly after cur_tid, wrapping.
module ctx_rr_pick #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned TID_W       = 2
) (
    input  logic [TID_W-1:0]       cur_tid,
    input  logic [NUM_THREADS-1:0] ready,
    output logic                   found,
    output logic [TID_W-1:0]       pick_tid
);

    always_comb begin
        found    = 1'b0;
        pick_tid = cur_tid;
        // walk offsets from farthest to nearest so the nearest ready one wins
        for (int k = NUM_THREADS - 1; k >= 1; k--) begin
            logic [TID_W-1:0] idx;
            idx = cur_tid + TID_W'(k);
            if (ready[idx]) begin
                found    = 1'b1;
                pick_tid = idx;
            end
        end
    end

endmodule

// File: rtl/ctx_pc_file.sv
// One PC per hardware thread with advance, rewind and redirect update ports.
module ctx_pc_file #(
    parameter int unsigned     NUM_THREADS = 4,
    parameter int unsigned     TID_W       = 2,
    parameter int unsigned     PC_W        = 32,
    parameter logic [PC_W-1:0] BOOT_ADDR   = 'h100,
    parameter int unsigned     PC_STEP     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_en,
    input  logic [TID_W-1:0] adv_tid,
    input  logic             rew_en,
    input  logic [TID_W-1:0] rew_tid,
    input  logic [PC_W-1:0]  rew_pc,
    input  logic             rdr_en,
    input  logic [TID_W-1:0] rdr_tid,
    input  logic [PC_W-1:0]  rdr_pc,
    input  logic [TID_W-1:0] rd_tid,
    output logic [PC_W-1:0]  rd_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    logic [NUM_THREADS-1:0][PC_W-1:0] pc_all;

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_ctx
        localparam logic [TID_W-1:0] MY_TID = TID_W'(g);

        logic [PC_W-1:0] pc_d;
        logic [PC_W-1:0] pc_q;

        always_comb begin
            pc_d = pc_q;
            if (adv_en && (adv_tid == MY_TID)) begin
                pc_d = pc_q + STEP;
            end
            if (rew_en && (rew_tid == MY_TID)) begin
                pc_d = rew_pc;
            end
            // a redirect overrides everything for its own thread
            if (rdr_en && (rdr_tid == MY_TID)) begin
                pc_d = rdr_pc;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pc_q <= BOOT_ADDR;
            end else begin
                pc_q <= pc_d;
            end
        end

        assign pc_all[g] = pc_q;
    end

    assign rd_pc = pc_all[rd_tid];

endmodule

// File: rtl/ctx_sched.sv
module ctx_sched #(
    parameter int unsigned                  NUM_THREADS = 4,
    parameter int unsigned                  PC_W        = 32,
    parameter logic [PC_W-1:0]              BOOT_ADDR   = 'h100,
    parameter int unsigned                  PC_STEP     = 4,
    parameter ctx_sched_pkg::sched_mode_e   MODE        = ctx_sched_pkg::SCHED_BLOCK,
    localparam int unsigned                 TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] thr_ready,
    input  logic                   ex_event,
    input  logic [TID_W-1:0]       ex_event_tid,
    input  logic                   redir_valid,
    input  logic [TID_W-1:0]       redir_tid,
    input  logic [PC_W-1:0]        redir_pc,
    output logic                   fetch_valid,
    output logic [TID_W-1:0]       fetch_tid,
    output logic [PC_W-1:0]        fetch_pc,
    output logic                   fetch_flush,
    output logic                   slot_valid,
    output logic [TID_W-1:0]       slot_tid
);

    typedef struct packed {
        logic [TID_W-1:0] act;       // thread owning fetch
        logic             slot_vld;  // instruction fetched last cycle is live
        logic [TID_W-1:0] slot_tid;  // its thread tag
        logic [PC_W-1:0]  slot_pc;   // its address, kept for rewind
    } sched_state_t;

    sched_state_t st_d, st_q;

    logic             pick_found;
    logic [TID_W-1:0] pick_tid;
    logic             do_switch;
    logic [TID_W-1:0] next_act;
    logic             fetch_go;
    logic             rew_en;
    logic [PC_W-1:0]  cur_pc;

    ctx_rr_pick #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) u_pick (
        .cur_tid  (st_q.act),
        .ready    (thr_ready),
        .found    (pick_found),
        .pick_tid (pick_tid)
    );

    if (MODE == ctx_sched_pkg::SCHED_INTERLEAVE) begin : g_interleave
        assign do_switch = 1'b0;
        assign next_act  = st_q.act + TID_W'(1);
    end else begin : g_block
        assign do_switch = ex_event && (ex_event_tid == st_q.act) && pick_found;
        assign next_act  = do_switch ? pick_tid : st_q.act;
    end

    // fetch proceeds unless the thread is parked or its slot is being refilled
    assign fetch_go = thr_ready[st_q.act] && !do_switch;
    assign rew_en   = do_switch && st_q.slot_vld && (st_q.slot_tid == st_q.act);

    ctx_pc_file #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W),
        .PC_W        (PC_W),
        .BOOT_ADDR   (BOOT_ADDR),
        .PC_STEP     (PC_STEP)
    ) u_pcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_en  (fetch_go),
        .adv_tid (st_q.act),
        .rew_en  (rew_en),
        .rew_tid (st_q.slot_tid),
        .rew_pc  (st_q.slot_pc),
        .rdr_en  (redir_valid),
        .rdr_tid (redir_tid),
        .rdr_pc  (redir_pc),
        .rd_tid  (st_q.act),
        .rd_pc   (cur_pc)
    );

    always_comb begin
        st_d          = st_q;
        st_d.act      = next_act;
        st_d.slot_vld = fetch_go;
        st_d.slot_tid = st_q.act;
        st_d.slot_pc  = cur_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_valid = fetch_go;
    assign fetch_tid   = st_q.act;
    assign fetch_pc    = cur_pc;
    assign fetch_flush = do_switch && st_q.slot_vld;
    assign slot_valid  = st_q.slot_vld;
    assign slot_tid    = st_q.slot_tid;

endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned TID_W       = 2,
    parameter bit          IS_IMT      = 1'b0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_THREADS-1:0] thr_ready,
    input logic                   ex_event,
    input logic [TID_W-1:0]       ex_event_tid,
    input logic                   fetch_valid,
    input logic [TID_W-1:0]       fetch_tid,
    input logic                   fetch_flush,
    input logic                   slot_valid,
    input logic [TID_W-1:0]       slot_tid
);

    // R4: an event tagged with another thread never flushes
    a_r4_foreign_event_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_event && (ex_event_tid != fetch_tid)) |-> !fetch_flush);

    // R5: a flush needs some other ready thread to switch to
    a_r5_flush_needs_target: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_flush |-> ((thr_ready & ~(NUM_THREADS'(1) << fetch_tid)) != '0));

    // R6: no fetch in a flush cycle, and the slot is empty afterwards
    a_r6_flush_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_flush |-> !fetch_valid);
    a_r6_slot_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_flush |=> !slot_valid);

    // R10: slot tag follows the previous fetch
    a_r10_slot_tracks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_flush |=> ((slot_valid == $past(fetch_valid)) &&
                          (!slot_valid || (slot_tid == $past(fetch_tid)))));

    if (IS_IMT) begin : g_imt_props
        // R9: strict rotation, never a flush
        a_r9_rotate: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (fetch_tid == TID_W'($past(fetch_tid) + 1)));
        a_r9_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
            !fetch_flush);
    end else begin : g_bmt_props
        // R3: without an event the active thread is held
        a_r3_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
            !ex_event |=> (fetch_tid == $past(fetch_tid)));
    end

endmodule

bind ctx_sched ctx_sched_chk #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W),
    .IS_IMT      (MODE == ctx_sched_pkg::SCHED_INTERLEAVE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_ready    (thr_ready),
    .ex_event     (ex_event),
    .ex_event_tid (ex_event_tid),
    .fetch_valid  (fetch_valid),
    .fetch_tid    (fetch_tid),
    .fetch_flush  (fetch_flush),
    .slot_valid   (slot_valid),
    .slot_tid     (slot_tid)
);

// File: tb/tb_ctx_sched.sv
module tb_ctx_sched;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    // block-mode instance
    logic [3:0]  rdy;
    logic        ev;
    logic [1:0]  ev_tid;
    logic        rv;
    logic [1:0]  rtid;
    logic [31:0] rpc;
    logic        fv, fl, sv;
    logic [1:0]  ft, st;
    logic [31:0] fpc;

    // interleaved-mode instance
    logic [3:0]  i_rdy;
    logic        i_ev;
    logic [1:0]  i_ev_tid;
    logic        i_rv;
    logic [1:0]  i_rtid;
    logic [31:0] i_rpc;
    logic        i_fv, i_fl, i_sv;
    logic [1:0]  i_ft, i_st;
    logic [31:0] i_fpc;

    ctx_sched #(.NUM_THREADS(4), .PC_W(32), .BOOT_ADDR(32'h100), .PC_STEP(4),
                .MODE(ctx_sched_pkg::SCHED_BLOCK)) dut (
        .clk(clk), .rst_n(rst_n), .thr_ready(rdy), .ex_event(ev), .ex_event_tid(ev_tid),
        .redir_valid(rv), .redir_tid(rtid), .redir_pc(rpc),
        .fetch_valid(fv), .fetch_tid(ft), .fetch_pc(fpc), .fetch_flush(fl),
        .slot_valid(sv), .slot_tid(st));

    ctx_sched #(.NUM_THREADS(4), .PC_W(32), .BOOT_ADDR(32'h100), .PC_STEP(4),
                .MODE(ctx_sched_pkg::SCHED_INTERLEAVE)) dut_imt (
        .clk(clk), .rst_n(rst_n), .thr_ready(i_rdy), .ex_event(i_ev), .ex_event_tid(i_ev_tid),
        .redir_valid(i_rv), .redir_tid(i_rtid), .redir_pc(i_rpc),
        .fetch_valid(i_fv), .fetch_tid(i_ft), .fetch_pc(i_fpc), .fetch_flush(i_fl),
        .slot_valid(i_sv), .slot_tid(i_st));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  rdy;
        logic        ev;
        logic [1:0]  evt;
        logic        rv;
        logic [1:0]  rt;
        logic [15:0] rpc;
        logic [1:0]  ft;
        logic [15:0] fpc;
        logic        fv;
        logic        fl;
        logic        sv;
        logic [1:0]  st;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{4'hF,1'b0,2'd0,1'b0,2'd0,16'h0,  2'd0,16'h100,1'b1,1'b0,1'b0,2'd0}, // 0 R1 R2
        '{4'hF,1'b0,2'd0,1'b0,2'd0,16'h0,  2'd0,16'h104,1'b1,1'b0,1'b1,2'd0}, // 1 R2 R10
        '{4'hF,1'b1,2'd0,1'b0,2'd0,16'h0,  2'd0,16'h108,1'b0,1'b1,1'b1,2'd0}, // 2 R6 switch 0->1
        '{4'hF,1'b0,2'd0,1'b0,2'd0,16'h0,  2'd1,16'h100,1'b1,1'b0,1'b0,2'd0}, // 3 R3
        '{4'hF,1'b1,2'd2,1'b0,2'd0,16'h0,  2'd1,16'h104,1'b1,1'b0,1'b1,2'd1}, // 4 R4 foreign event
        '{4'hA,1'b1,2'd1,1'b0,2'd0,16'h0,  2'd1,16'h108,1'b0,1'b1,1'b1,2'd1}, // 5 R3 skip 2 -> 3
        '{4'h8,1'b0,2'd0,1'b0,2'd0,16'h0,  2'd3,16'h100,1'b1,1'b0,1'b0,2'd0}, // 6
        '{4'h8,1'b1,2'd3,1'b0,2'd0,16'h0,  2'd3,16'h104,1'b1,1'b0,1'b1,2'd3}, // 7 R5 alone
        '{4'h1,1'b1,2'd3,1'b0,2'd0,16'h0,  2'd3,16'h108,1'b0,1'b1,1'b1,2'd3}, // 8 R3 wrap 3->0
        '{4'hF,1'b0,2'd0,1'b1,2'd2,16'h200,2'd0,16'h104,1'b1,1'b0,1'b0,2'd0}, // 9 R7 refetch, R8
        '{4'hF,1'b1,2'd0,1'b0,2'd0,16'h0,  2'd0,16'h108,1'b0,1'b1,1'b1,2'd0}, // 10 switch 0->1
        '{4'h0,1'b0,2'd0,1'b0,2'd0,16'h0,  2'd1,16'h104,1'b0,1'b0,1'b0,2'd0}, // 11 R7 rewound, R2 parked
        '{4'hF,1'b1,2'd1,1'b0,2'd0,16'h0,  2'd1,16'h104,1'b0,1'b0,1'b0,2'd0}, // 12 R6 switch, empty slot
        '{4'hF,1'b0,2'd0,1'b1,2'd2,16'h300,2'd2,16'h200,1'b1,1'b0,1'b0,2'd0}, // 13 R8 beats advance
        '{4'hF,1'b0,2'd0,1'b0,2'd0,16'h0,  2'd2,16'h300,1'b1,1'b0,1'b1,2'd2}, // 14 R8
        '{4'hF,1'b1,2'd2,1'b0,2'd0,16'h0,  2'd2,16'h304,1'b0,1'b1,1'b1,2'd2}, // 15 switch 2->3
        '{4'hF,1'b0,2'd0,1'b0,2'd0,16'h0,  2'd3,16'h104,1'b1,1'b0,1'b0,2'd0}, // 16 R7
        '{4'hF,1'b1,2'd3,1'b0,2'd0,16'h0,  2'd3,16'h108,1'b0,1'b1,1'b1,2'd3}, // 17 R3 wrap
        '{4'hF,1'b0,2'd0,1'b0,2'd0,16'h0,  2'd0,16'h104,1'b1,1'b0,1'b0,2'd0}  // 18 R7
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        rdy = 4'hF; ev = 1'b0; ev_tid = '0; rv = 1'b0; rtid = '0; rpc = '0;
        i_rdy = 4'hF; i_ev = 1'b0; i_ev_tid = '0; i_rv = 1'b0; i_rtid = '0; i_rpc = '0;

        // R1: state during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset fetch_tid", 32'(ft), 32'd0);
        check("R1", "reset fetch_pc", fpc, 32'h100);
        check("R1", "reset slot_valid", 32'(sv), 32'd0);
        rst_n = 1'b1;

        // block mode, vector table
        for (int i = 0; i < NV; i++) begin
            rdy = VEC[i].rdy; ev = VEC[i].ev; ev_tid = VEC[i].evt;
            rv = VEC[i].rv; rtid = VEC[i].rt; rpc = 32'(VEC[i].rpc);
            #1;
            check("R3", $sformatf("v%0d fetch_tid", i), 32'(ft), 32'(VEC[i].ft));
            check("R2", $sformatf("v%0d fetch_pc", i), fpc, 32'(VEC[i].fpc));
            check("R6", $sformatf("v%0d fetch_valid", i), 32'(fv), 32'(VEC[i].fv));
            check("R6", $sformatf("v%0d fetch_flush", i), 32'(fl), 32'(VEC[i].fl));
            check("R10", $sformatf("v%0d slot_valid", i), 32'(sv), 32'(VEC[i].sv));
            if (VEC[i].sv)
                check("R10", $sformatf("v%0d slot_tid", i), 32'(st), 32'(VEC[i].st));
            @(posedge clk);
            @(negedge clk);
        end
        rdy = 4'hF; ev = 1'b0; rv = 1'b0;

        // R1: reset in mid-run restores both instances
        rst_n = 1'b0;
        #1;
        check("R1", "rerun block fetch_tid", 32'(ft), 32'd0);
        check("R1", "rerun block fetch_pc", fpc, 32'h100);
        check("R1", "rerun block slot_valid", 32'(sv), 32'd0);
        check("R1", "rerun imt fetch_tid", 32'(i_ft), 32'd0);
        check("R1", "rerun imt fetch_pc", i_fpc, 32'h100);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: interleaved rotation, thread 2 parked, events present, redirect mid-run
        begin
            logic [31:0] mpc [4];
            logic        p_v;
            logic [1:0]  p_t;
            for (int t = 0; t < 4; t++) mpc[t] = 32'h100;
            p_v = 1'b0;
            p_t = 2'd0;
            i_rdy = 4'b1011;
            for (int c = 0; c < 10; c++) begin
                logic [1:0] et;
                logic       ev_ok;
                et = 2'(c);
                ev_ok = i_rdy[et];
                i_ev = 1'b1;
                i_ev_tid = et;
                i_rv = (c == 5);
                i_rtid = 2'd0;
                i_rpc = 32'h400;
                #1;
                check("R9", $sformatf("imt c%0d fetch_tid", c), 32'(i_ft), 32'(et));
                check("R9", $sformatf("imt c%0d fetch_valid", c), 32'(i_fv), 32'(ev_ok));
                check("R9", $sformatf("imt c%0d fetch_flush", c), 32'(i_fl), 32'd0);
                check("R8", $sformatf("imt c%0d fetch_pc", c), i_fpc, mpc[et]);
                check("R10", $sformatf("imt c%0d slot_valid", c), 32'(i_sv), 32'(p_v));
                if (p_v)
                    check("R10", $sformatf("imt c%0d slot_tid", c), 32'(i_st), 32'(p_t));
                if (ev_ok) mpc[et] = mpc[et] + 32'd4;
                if (c == 5) mpc[0] = 32'h400;
                p_v = ev_ok;
                p_t = et;
                @(posedge clk);
                @(negedge clk);
            end
            i_ev = 1'b0;
            i_rv = 1'b0;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule